// File: doc/BRIEF.md
# Cascaded Delay Setting Stepper

This block holds the delay setting of a single bytelane. The setting is split into four chained fields. From finest to coarsest they are a phase-interpolator step, a tap count, a clock-delay count and a coarse count. A calibration sequencer moves the setting one phase-interpolator unit at a time, either down or up. The sequencer uses this while it walks a strobe towards the edge at which the sampled data turns from low to high.

Each step borrows or carries between the fields in the manner of a mixed-radix counter:

- The phase-interpolator field always spans 0 to 6.
- The tap field spans 0 to a ceiling that depends on the memory speed grade.
- The clock-delay and coarse fields use their full binary range.

Borrowing out of the coarse field has a special rule. It leaves clock delay at one instead of wrapping it. A step that would run past either end of the range is refused, and the block flags an error.

The packed setting is `{coarse, clk_delay, tap, pi}`, with `pi` in the least significant bits. Every accepted load or step shows up one cycle later, together with a one-cycle update strobe. Driving the setting into a physical delay line is left to the consumer of that strobe.

Top module: `dly_step_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `setting` is zero and both `upd_vld` and `step_err` are low.
- R2: With `load_en` high, `setting` takes `load_val` on the next cycle and `upd_vld` pulses. A load wins over any step request in the same cycle.
- R3: A down-step with `pi` above zero lowers only `pi` by one.
- R4: A down-step with `pi` zero and `tap` above zero sets `pi` to 6 and lowers `tap` by one. `clk_delay` and `coarse` stay unchanged.
- R5: A down-step with `pi` and `tap` zero and `clk_delay` above zero sets `pi` to 6 and `tap` to the grade ceiling, and lowers `clk_delay` by one.
- R6: A down-step where only `coarse` is nonzero sets `pi` to 6, `tap` to the grade ceiling and `clk_delay` to one, and lowers `coarse` by one.
- R7: A down-step at the all-zero setting leaves `setting` unchanged, pulses `step_err` on the next cycle and gives no `upd_vld`.
- R8: The tap ceiling follows `grade`: code 0 gives 14, code 1 gives 11, code 2 gives 8, and the unused code 3 behaves as code 0.
- R9: An up-step with `pi` below 6 raises `pi` by one. With `pi` at 6 or above, `pi` clears and `tap` rises by one while `tap` is below its ceiling.
- R10: An up-step with `pi` at 6 and `tap` at or above its ceiling clears both. It then raises `clk_delay` if that field is below 7. Otherwise it clears `clk_delay` and raises `coarse`.
- R11: An up-step at the top setting (`pi`≥6, `tap`≥ceiling, `clk_delay`=7, `coarse`=3) leaves `setting` unchanged, pulses `step_err` and gives no `upd_vld`.
- R12: A cycle that raises both step inputs without a load, or that raises neither, leaves `setting` unchanged, with no `upd_vld` and no `step_err`.
- R13: An accepted load or step raises `upd_vld` for exactly one cycle, the cycle after the request, and `upd_vld` and `step_err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grade | input | 2 | Speed grade code selecting the tap ceiling |
| load_en | input | 1 | Preset all fields from `load_val` |
| load_val | input | 12 | Packed preset value `{coarse, clk_delay, tap, pi}` |
| step_dn | input | 1 | Request one unit down |
| step_up | input | 1 | Request one unit up |
| setting | output | 12 | Packed current setting `{coarse[11:10], clk_delay[9:7], tap[6:3], pi[2:0]}` |
| upd_vld | output | 1 | One-cycle strobe: the setting was just updated |
| step_err | output | 1 | One-cycle flag: the last step was refused at a range end |

## Verification
A wrong borrow or carry shows up on `setting` in the cycle directly after the step. It appears as a field that failed to reload to 6 or to the tap ceiling, or as a neighbouring field that moved when it should have held. A wrong ceiling only becomes visible when a borrow passes through the tap field, so each grade code is driven through such a borrow. A missed range check shows either as a wrapped setting where `step_err` should have pulsed, or as a stray `upd_vld`, again one cycle after the request. Long up-runs compared against an independent model catch errors that only build up across many carries.

// File: rtl/dly_step_ctrl.sv
module dly_step_ctrl #(
  parameter int TAP_W      = 4,
  parameter int CLKD_W     = 3,
  parameter int CRS_W      = 2,
  parameter int PI_TOP     = 6,
  parameter int TAP_MAX_G0 = 14,
  parameter int TAP_MAX_G1 = 11,
  parameter int TAP_MAX_G2 = 8,
  localparam int PI_W      = $clog2(PI_TOP + 1),
  localparam int SET_W     = PI_W + TAP_W + CLKD_W + CRS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       grade,
  input  logic             load_en,
  input  logic [SET_W-1:0] load_val,
  input  logic             step_dn,
  input  logic             step_up,
  output logic [SET_W-1:0] setting,
  output logic             upd_vld,
  output logic             step_err
);

  localparam logic [PI_W-1:0]   PI_RELOAD = PI_W'(PI_TOP);
  localparam logic [CLKD_W-1:0] CD_TOP    = '1;
  localparam logic [CRS_W-1:0]  CR_TOP    = '1;

  logic [PI_W-1:0]   pi_q,  pi_d;
  logic [TAP_W-1:0]  tap_q, tap_d, tap_max;
  logic [CLKD_W-1:0] cd_q,  cd_d;
  logic [CRS_W-1:0]  cr_q,  cr_d;

  wire dn_go   = step_dn & ~step_up & ~load_en;
  wire up_go   = step_up & ~step_dn & ~load_en;
  wire at_zero = (pi_q == '0) && (tap_q == '0) && (cd_q == '0) && (cr_q == '0);
  wire at_top  = (pi_q >= PI_RELOAD) && (tap_q >= tap_max) &&
                 (cd_q == CD_TOP) && (cr_q == CR_TOP);

  always_comb begin
    case (grade)
      2'd1:    tap_max = TAP_W'(TAP_MAX_G1);
      2'd2:    tap_max = TAP_W'(TAP_MAX_G2);
      default: tap_max = TAP_W'(TAP_MAX_G0);
    endcase
  end

  always_comb begin
    pi_d  = pi_q;
    tap_d = tap_q;
    cd_d  = cd_q;
    cr_d  = cr_q;
    if (load_en) begin
      {cr_d, cd_d, tap_d, pi_d} = load_val;
    end else if (dn_go) begin
      if (pi_q != '0) begin
        pi_d = pi_q - 1'b1;
      end else if (tap_q != '0) begin
        pi_d  = PI_RELOAD;
        tap_d = tap_q - 1'b1;
      end else if (cd_q != '0) begin
        pi_d  = PI_RELOAD;
        tap_d = tap_max;
        cd_d  = cd_q - 1'b1;
      end else if (cr_q != '0) begin
        pi_d  = PI_RELOAD;
        tap_d = tap_max;
        cd_d  = cd_q + 1'b1;
        cr_d  = cr_q - 1'b1;
      end
    end else if (up_go) begin
      if (pi_q < PI_RELOAD) begin
        pi_d = pi_q + 1'b1;
      end else if (tap_q < tap_max) begin
        pi_d  = '0;
        tap_d = tap_q + 1'b1;
      end else if (cd_q != CD_TOP) begin
        pi_d  = '0;
        tap_d = '0;
        cd_d  = cd_q + 1'b1;
      end else if (cr_q != CR_TOP) begin
        pi_d  = '0;
        tap_d = '0;
        cd_d  = '0;
        cr_d  = cr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pi_q     <= '0;
      tap_q    <= '0;
      cd_q     <= '0;
      cr_q     <= '0;
      upd_vld  <= 1'b0;
      step_err <= 1'b0;
    end else begin
      pi_q     <= pi_d;
      tap_q    <= tap_d;
      cd_q     <= cd_d;
      cr_q     <= cr_d;
      upd_vld  <= load_en | (dn_go & ~at_zero) | (up_go & ~at_top);
      step_err <= (dn_go & at_zero) | (up_go & at_top);
    end
  end

  assign setting = {cr_q, cd_q, tap_q, pi_q};

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (setting == $past(load_val)) && upd_vld); // R2

  AST_DN_PI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_go && pi_q != '0) |=> (pi_q == PI_W'($past(pi_q) - 1'b1)) &&
      $stable(tap_q) && $stable(cd_q) && $stable(cr_q)); // R3

  AST_COARSE_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_go && pi_q == '0 && tap_q == '0 && cd_q == '0 && cr_q != '0) |=>
      (cd_q == CLKD_W'(1)) && (pi_q == PI_RELOAD) &&
      (cr_q == CRS_W'($past(cr_q) - 1'b1))); // R6

  AST_ZERO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_go && at_zero) |=> step_err && !upd_vld && $stable(setting)); // R7

  AST_TOP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (up_go && at_top) |=> step_err && !upd_vld && $stable(setting)); // R11

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && (step_dn == step_up)) |=> $stable(setting) && !upd_vld && !step_err); // R12

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({upd_vld, step_err}) <= 1); // R13

endmodule

// File: tb/dly_step_ctrl_test.sv
module dly_step_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  grade = 2'd0;
  logic        load_en = 1'b0;
  logic [11:0] load_val = '0;
  logic        step_dn = 1'b0;
  logic        step_up = 1'b0;
  logic [11:0] setting;
  logic        upd_vld;
  logic        step_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [11:0] s;
    logic        v;
    logic        e;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [11:0] m = '0;

  always #4 clk = ~clk;

  dly_step_ctrl uut (
    .clk(clk), .rst_n(rst_n), .grade(grade), .load_en(load_en),
    .load_val(load_val), .step_dn(step_dn), .step_up(step_up),
    .setting(setting), .upd_vld(upd_vld), .step_err(step_err)
  );

  function automatic logic [11:0] pk(int cr, int cd, int tp, int p);
    return {2'(cr), 3'(cd), 4'(tp), 3'(p)};
  endfunction

  function automatic int ceil_of(logic [1:0] g);
    return (g == 2'd1) ? 11 : (g == 2'd2) ? 8 : 14;
  endfunction

  task automatic drive(input logic ld, input logic [11:0] v, input logic dn,
                       input logic up, input logic [1:0] g, input string tag);
    exp_t x;
    int p, tp, cd, cr, tm;
    @(negedge clk);
    load_en = ld; load_val = v; step_dn = dn; step_up = up; grade = g;
    p = m[2:0]; tp = m[6:3]; cd = m[9:7]; cr = m[11:10]; tm = ceil_of(g);
    x.v = 1'b0; x.e = 1'b0; x.tag = tag;
    if (ld) begin
      m = v; x.v = 1'b1;
    end else if (dn && !up) begin
      if (p > 0)       begin p--; x.v = 1'b1; end
      else if (tp > 0) begin p = 6; tp--; x.v = 1'b1; end
      else if (cd > 0) begin p = 6; tp = tm; cd--; x.v = 1'b1; end
      else if (cr > 0) begin p = 6; tp = tm; cd = 1; cr--; x.v = 1'b1; end
      else x.e = 1'b1;
      m = pk(cr, cd, tp, p);
    end else if (up && !dn) begin
      if (p < 6)        begin p++; x.v = 1'b1; end
      else if (tp < tm) begin p = 0; tp++; x.v = 1'b1; end
      else if (cd < 7)  begin p = 0; tp = 0; cd++; x.v = 1'b1; end
      else if (cr < 3)  begin p = 0; tp = 0; cd = 0; cr++; x.v = 1'b1; end
      else x.e = 1'b1;
      m = pk(cr, cd, tp, p);
    end
    x.s = m;
    sb.push_back(x);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        checks++;
        if (setting !== x.s || upd_vld !== x.v || step_err !== x.e) begin
          fails++;
          $display("FAIL %s: got setting=%h vld=%b err=%b, expected setting=%h vld=%b err=%b",
                   x.tag, setting, upd_vld, step_err, x.s, x.v, x.e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (setting !== '0 || upd_vld !== 1'b0 || step_err !== 1'b0) begin
      fails++;
      $display("FAIL R1: got %h/%b/%b, expected 000/0/0", setting, upd_vld, step_err);
    end
    rst_n = 1'b1;
    drive(0, '0, 0, 0, 0, "R1 idle after reset");
    drive(1, pk(2, 0, 0, 2), 0, 0, 0, "R2 load");
    drive(0, '0, 1, 0, 0, "R3 pi down");
    drive(0, '0, 1, 0, 0, "R3 pi down to zero");
    drive(0, '0, 1, 0, 0, "R6 coarse borrow");
    drive(0, '0, 1, 0, 0, "R3 pi down after borrow");
    drive(1, pk(0, 0, 2, 0), 0, 0, 0, "R2 load");
    drive(0, '0, 1, 0, 0, "R4 tap borrow");
    drive(1, pk(0, 3, 0, 0), 0, 0, 1, "R2 load");
    drive(0, '0, 1, 0, 1, "R5 R8 clk borrow grade1");
    drive(1, pk(0, 1, 0, 0), 0, 0, 2, "R2 load");
    drive(0, '0, 1, 0, 2, "R5 R8 clk borrow grade2");
    drive(1, pk(0, 1, 0, 0), 0, 0, 3, "R2 load");
    drive(0, '0, 1, 0, 3, "R8 grade3 as grade0");
    drive(1, pk(3, 0, 0, 0), 0, 0, 0, "R2 load");
    drive(0, '0, 1, 0, 0, "R6 borrow grade0");
    drive(1, '0, 0, 0, 0, "R2 load zero");
    drive(0, '0, 1, 0, 0, "R7 down at zero");
    drive(0, '0, 0, 0, 0, "R7 setting still zero");
    drive(0, '0, 0, 1, 0, "R9 pi up");
    drive(1, pk(0, 2, 3, 6), 0, 0, 0, "R2 load");
    drive(0, '0, 0, 1, 0, "R9 pi wrap into tap");
    drive(1, pk(0, 2, 11, 6), 0, 0, 1, "R2 load");
    drive(0, '0, 0, 1, 1, "R10 tap carry to clk");
    drive(1, pk(1, 7, 14, 6), 0, 0, 0, "R2 load");
    drive(0, '0, 0, 1, 0, "R10 clk carry to coarse");
    drive(1, pk(3, 7, 14, 6), 0, 0, 0, "R2 load top");
    drive(0, '0, 0, 1, 0, "R11 up at top");
    drive(0, '0, 0, 0, 0, "R11 top held");
    drive(0, '0, 1, 1, 0, "R12 both steps");
    drive(0, '0, 0, 0, 0, "R12 idle");
    drive(1, pk(0, 1, 1, 1), 1, 0, 0, "R2 load beats step");
    drive(0, '0, 0, 0, 0, "R13 strobe single cycle");
    drive(1, '0, 0, 0, 2, "R2 load zero");
    for (int i = 0; i < 60; i++) drive(0, '0, 0, 1, 2, "R9 R10 up run");
    for (int i = 0; i < 70; i++) drive(0, '0, 1, 0, 2, "R3 R4 R5 down run");
    drive(0, '0, 0, 0, 0, "R12 final idle");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule